// File: doc/BRIEF.md
# Dual-Clock Two-Port RAM with Selectable Write-Output Behaviour

This block is a synchronous memory with two fully independent ports. Each port has its own clock and can read or write any location. A location holds a data word together with a narrower parity word, and both are always stored and returned together. Each port presents its read result through a registered output latch. On every edge of its own clock, a port's control inputs decide whether that latch holds, loads a programmable reset value, loads the addressed location, or follows the port's chosen write behaviour.

Each port has its own elaboration-time settings. The write behaviour can be one of three: the output shows the incoming word (write-first), the output shows the word being overwritten (read-first), or the output stays as it was (no-change). The settings also fix the latch's synchronous reset value and the value the latch takes on the asynchronous global reset. The memory starts with computed contents: the full word at address `i` is the low bits of `i*37 + SEED`.

Top module: `tdp_ram_wm`

## Requirements
- R1: Each port's output latch changes only on a rising edge of that port's own clock (or on global reset). An operation on one port leaves the other port's outputs unchanged.
- R2: With a port's enable low, its output latches hold their values, and a write enable or set/reset on that port leaves memory unchanged.
- R3: With enable and set/reset high and write enable low, the port's full output word ({parity, data}) loads that port's SRVAL parameter, and memory is not modified.
- R4: With enable, set/reset and write enable all high, the output loads SRVAL, and the input word is still written to the addressed location on the same edge.
- R5: With enable high and set/reset and write enable low, the output loads the addressed location one edge later.
- R6: On a port in write-first mode, a write without set/reset puts the new {parity, data} input on the output at the same edge that stores it.
- R7: On a port in read-first mode, a write without set/reset puts the location's previous contents on the output while it stores the new word.
- R8: On a port in no-change mode, a write without set/reset stores the new word and leaves the output latches unchanged.
- R9: While the global reset is high, each port's output word equals that port's INIT parameter, with no clock edge needed.
- R10: Data and parity form one word, with the data in the low DW bits and the parity in the next PW bits. Before any write, location i holds the low DW+PW bits of i*37+SEED.
- R11: A word written through either port is returned by a later read on the other port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| glob_rst | input | 1 | Asynchronous global reset; loads both output latches with their INIT values |
| a_clk | input | 1 | Port A clock |
| a_en | input | 1 | Port A enable |
| a_srst | input | 1 | Port A synchronous output set/reset |
| a_we | input | 1 | Port A write enable |
| a_addr | input | $clog2(DEPTH) | Port A address |
| a_din | input | DW | Port A write data |
| a_pin | input | PW | Port A write parity |
| a_dout | output | DW | Port A data output latch |
| a_pout | output | PW | Port A parity output latch |
| b_clk | input | 1 | Port B clock |
| b_en | input | 1 | Port B enable |
| b_srst | input | 1 | Port B synchronous output set/reset |
| b_we | input | 1 | Port B write enable |
| b_addr | input | $clog2(DEPTH) | Port B address |
| b_din | input | DW | Port B write data |
| b_pin | input | PW | Port B write parity |
| b_dout | output | DW | Port B data output latch |
| b_pout | output | PW | Port B parity output latch |

## Verification
The assertions assume that the global reset rises and falls between clock edges and is held across at least one edge of each clock. They also assume that the two ports never write the same address in overlapping cycles, since that case has no defined result. The bench meets both assumptions. It applies every operation to one port at a time, with inputs driven on the falling edge of that port's clock. Its global reset pulses start and end off any edge and last long enough to span edges of both clocks.

// File: rtl/tdp_ram_pkg.sv
package tdp_ram_pkg;

    typedef enum logic [1:0] {
        WM_WRITE_FIRST = 2'd0,
        WM_READ_FIRST  = 2'd1,
        WM_KEEP        = 2'd2
    } wr_mode_e;

    // Power-up word of a location; callers keep the low bits they need.
    function automatic logic [63:0] init_word(input int addr, input int seed);
        return 64'(addr * 37 + seed);
    endfunction

endpackage

// File: rtl/tdp_ram_bank.sv
// Storage written by exactly one port, readable at both port addresses.
// Each location also keeps a flag bit used to find the newest copy.
module tdp_ram_bank
    import tdp_ram_pkg::*;
#(
    parameter int W     = 9,
    parameter int DEPTH = 2048,
    parameter int SEED  = 0,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [W-1:0]  wr_data,
    input  logic          wr_flag,
    input  logic [AW-1:0] rd_addr0,
    input  logic [AW-1:0] rd_addr1,
    output logic [W-1:0]  rd_data0,
    output logic [W-1:0]  rd_data1,
    output logic          rd_flag0,
    output logic          rd_flag1
);

    logic [W-1:0] mem_q [DEPTH];
    logic         flg_q [DEPTH];

    initial begin
        for (int i = 0; i < DEPTH; i++) begin
            mem_q[i] = W'(init_word(i, SEED));
            flg_q[i] = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem_q[wr_addr] <= wr_data;
            flg_q[wr_addr] <= wr_flag;
        end
    end

    assign rd_data0 = mem_q[rd_addr0];
    assign rd_data1 = mem_q[rd_addr1];
    assign rd_flag0 = flg_q[rd_addr0];
    assign rd_flag1 = flg_q[rd_addr1];

endmodule

// File: rtl/tdp_ram_port.sv
// Output latch of one port: hold, set/reset value, read, or write view.
module tdp_ram_port
    import tdp_ram_pkg::*;
#(
    parameter int           DW    = 8,
    parameter int           PW    = 1,
    parameter wr_mode_e     MODE  = WM_WRITE_FIRST,
    parameter logic [DW+PW-1:0] SRVAL = '0,
    parameter logic [DW+PW-1:0] INITV = '0,
    localparam int          W     = DW + PW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic          srst,
    input  logic          we,
    input  logic [DW-1:0] din,
    input  logic [PW-1:0] pin,
    input  logic [W-1:0]  rd_word,
    output logic [DW-1:0] dout,
    output logic [PW-1:0] pout
);

    typedef struct packed {
        logic [PW-1:0] p;
        logic [DW-1:0] d;
    } lat_t;

    lat_t lat_d, lat_q;
    lat_t wr_view;
    lat_t rd_view;

    assign rd_view = lat_t'(rd_word);

    // The output seen during a write is fixed at elaboration.
    generate
        if (MODE == WM_WRITE_FIRST) begin : g_wf
            assign wr_view = '{p: pin, d: din};
        end else if (MODE == WM_READ_FIRST) begin : g_rf
            assign wr_view = rd_view;
        end else begin : g_keep
            assign wr_view = lat_q;
        end
    endgenerate

    always_comb begin
        lat_d = lat_q;
        if (en) begin
            if (srst) begin
                lat_d = lat_t'(SRVAL);
            end else if (we) begin
                lat_d = wr_view;
            end else begin
                lat_d = rd_view;
            end
        end
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            lat_q <= lat_t'(INITV);
        end else begin
            lat_q <= lat_d;
        end
    end

    assign dout = lat_q.d;
    assign pout = lat_q.p;

endmodule

// File: rtl/tdp_ram_wm.sv
// Two-port RAM. Each port writes its own bank; a per-location flag pair
// records which bank holds the newest word.
module tdp_ram_wm
    import tdp_ram_pkg::*;
#(
    parameter int       DW     = 8,
    parameter int       PW     = 1,
    parameter int       DEPTH  = 2048,
    parameter int       SEED   = 0,
    parameter wr_mode_e MODE_A = WM_WRITE_FIRST,
    parameter wr_mode_e MODE_B = WM_WRITE_FIRST,
    parameter logic [DW+PW-1:0] SRVAL_A = '0,
    parameter logic [DW+PW-1:0] SRVAL_B = '0,
    parameter logic [DW+PW-1:0] INIT_A  = '0,
    parameter logic [DW+PW-1:0] INIT_B  = '0
) (
    input  logic                     glob_rst,
    input  logic                     a_clk,
    input  logic                     a_en,
    input  logic                     a_srst,
    input  logic                     a_we,
    input  logic [$clog2(DEPTH)-1:0] a_addr,
    input  logic [DW-1:0]            a_din,
    input  logic [PW-1:0]            a_pin,
    output logic [DW-1:0]            a_dout,
    output logic [PW-1:0]            a_pout,
    input  logic                     b_clk,
    input  logic                     b_en,
    input  logic                     b_srst,
    input  logic                     b_we,
    input  logic [$clog2(DEPTH)-1:0] b_addr,
    input  logic [DW-1:0]            b_din,
    input  logic [PW-1:0]            b_pin,
    output logic [DW-1:0]            b_dout,
    output logic [PW-1:0]            b_pout
);

    localparam int AW = $clog2(DEPTH);
    localparam int W  = DW + PW;
    localparam int NP = 2;

    logic [NP-1:0] clk_v, en_v, srst_v, we_v;
    logic [AW-1:0] addr_v  [NP];
    logic [DW-1:0] din_v   [NP];
    logic [PW-1:0] pin_v   [NP];
    logic [DW-1:0] dout_v  [NP];
    logic [PW-1:0] pout_v  [NP];
    logic [W-1:0]  rdat    [NP][NP];   // [bank][reading port]
    logic          rflag   [NP][NP];   // [bank][reading port]
    logic [W-1:0]  rword_v [NP];
    logic          wflag_v [NP];

    assign clk_v  = {b_clk,  a_clk};
    assign en_v   = {b_en,   a_en};
    assign srst_v = {b_srst, a_srst};
    assign we_v   = {b_we,   a_we};
    assign addr_v[0] = a_addr;
    assign addr_v[1] = b_addr;
    assign din_v[0]  = a_din;
    assign din_v[1]  = b_din;
    assign pin_v[0]  = a_pin;
    assign pin_v[1]  = b_pin;

    // Port A makes the flags equal, port B makes them differ.
    assign wflag_v[0] = rflag[1][0];
    assign wflag_v[1] = ~rflag[0][1];

    generate
        for (genvar g = 0; g < NP; g++) begin : g_port
            assign rword_v[g] = (rflag[0][g] == rflag[1][g]) ? rdat[0][g]
                                                              : rdat[1][g];

            tdp_ram_bank #(
                .W     (W),
                .DEPTH (DEPTH),
                .SEED  (SEED)
            ) u_bank (
                .clk      (clk_v[g]),
                .wr_en    (en_v[g] & we_v[g]),
                .wr_addr  (addr_v[g]),
                .wr_data  ({pin_v[g], din_v[g]}),
                .wr_flag  (wflag_v[g]),
                .rd_addr0 (addr_v[0]),
                .rd_addr1 (addr_v[1]),
                .rd_data0 (rdat[g][0]),
                .rd_data1 (rdat[g][1]),
                .rd_flag0 (rflag[g][0]),
                .rd_flag1 (rflag[g][1])
            );

            tdp_ram_port #(
                .DW    (DW),
                .PW    (PW),
                .MODE  ((g == 0) ? MODE_A : MODE_B),
                .SRVAL ((g == 0) ? SRVAL_A : SRVAL_B),
                .INITV ((g == 0) ? INIT_A : INIT_B)
            ) u_port (
                .clk     (clk_v[g]),
                .rst     (glob_rst),
                .en      (en_v[g]),
                .srst    (srst_v[g]),
                .we      (we_v[g]),
                .din     (din_v[g]),
                .pin     (pin_v[g]),
                .rd_word (rword_v[g]),
                .dout    (dout_v[g]),
                .pout    (pout_v[g])
            );
        end
    endgenerate

    assign a_dout = dout_v[0];
    assign a_pout = pout_v[0];
    assign b_dout = dout_v[1];
    assign b_pout = pout_v[1];

endmodule

// File: rtl/tdp_ram_wm_chk.sv
module tdp_ram_wm_chk
    import tdp_ram_pkg::*;
#(
    parameter int       DW    = 8,
    parameter int       PW    = 1,
    parameter wr_mode_e MODE  = WM_WRITE_FIRST,
    parameter logic [DW+PW-1:0] SRVAL = '0
) (
    input logic          clk,
    input logic          rst,
    input logic          en,
    input logic          srst,
    input logic          we,
    input logic [DW-1:0] din,
    input logic [PW-1:0] pin,
    input logic [DW-1:0] dout,
    input logic [PW-1:0] pout
);

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable({pout, dout})) else $error("idle port changed"); // R2

    AST_SRST_LOADS: assert property (@(posedge clk) disable iff (rst)
        (en && srst) |=> ({pout, dout} == SRVAL)) else $error("srst value"); // R3

    AST_WF_FORWARDS: assert property (@(posedge clk) disable iff (rst)
        ((MODE == WM_WRITE_FIRST) && en && !srst && we)
        |=> ({pout, dout} == $past({pin, din}))) else $error("wf output"); // R6

    AST_KEEP_FROZEN: assert property (@(posedge clk) disable iff (rst)
        ((MODE == WM_KEEP) && en && !srst && we)
        |=> $stable({pout, dout})) else $error("keep output"); // R8

endmodule

bind tdp_ram_wm tdp_ram_wm_chk #(
    .DW(DW), .PW(PW), .MODE(MODE_A), .SRVAL(SRVAL_A)
) u_chk_a (
    .clk(a_clk), .rst(glob_rst), .en(a_en), .srst(a_srst), .we(a_we),
    .din(a_din), .pin(a_pin), .dout(a_dout), .pout(a_pout)
);

bind tdp_ram_wm tdp_ram_wm_chk #(
    .DW(DW), .PW(PW), .MODE(MODE_B), .SRVAL(SRVAL_B)
) u_chk_b (
    .clk(b_clk), .rst(glob_rst), .en(b_en), .srst(b_srst), .we(b_we),
    .din(b_din), .pin(b_pin), .dout(b_dout), .pout(b_pout)
);

// File: tb/test_tdp_ram_wm.sv
`timescale 1ns/1ps
module test_tdp_ram_wm;
    import tdp_ram_pkg::*;

    localparam int DW = 8, PW = 1, DEPTH = 2048, AW = 11, W = 9, SEED = 5;
    localparam wr_mode_e MA = WM_WRITE_FIRST, MB = WM_READ_FIRST;
    localparam logic [W-1:0] SRA = 9'h1A5, SRB = 9'h05A;
    localparam logic [W-1:0] INA = 9'h0F0, INB = 9'h10F;
    localparam logic [W-1:0] SRN = 9'h133, INN = 9'h0AA;

    logic glob_rst = 1'b1;
    logic a_clk = 1'b0, b_clk = 1'b0;
    logic a_en = 0, a_srst = 0, a_we = 0;
    logic [AW-1:0] a_addr = '0;
    logic [DW-1:0] a_din = '0;
    logic [PW-1:0] a_pin = '0;
    logic [DW-1:0] a_dout;
    logic [PW-1:0] a_pout;
    logic b_en = 0, b_srst = 0, b_we = 0;
    logic [AW-1:0] b_addr = '0;
    logic [DW-1:0] b_din = '0;
    logic [PW-1:0] b_pin = '0;
    logic [DW-1:0] b_dout;
    logic [PW-1:0] b_pout;
    // second instance, port A no-change
    logic n_en = 0, n_srst = 0, n_we = 0;
    logic [AW-1:0] n_addr = '0;
    logic [DW-1:0] n_din = '0;
    logic [PW-1:0] n_pin = '0;
    logic [DW-1:0] n_dout, nb_dout;
    logic [PW-1:0] n_pout, nb_pout;

    always #4 a_clk = ~a_clk;   // 125 MHz
    always #6 b_clk = ~b_clk;

    tdp_ram_wm #(.DW(DW), .PW(PW), .DEPTH(DEPTH), .SEED(SEED),
        .MODE_A(MA), .MODE_B(MB), .SRVAL_A(SRA), .SRVAL_B(SRB),
        .INIT_A(INA), .INIT_B(INB)) i_tdp_ram_wm (
        .glob_rst(glob_rst),
        .a_clk(a_clk), .a_en(a_en), .a_srst(a_srst), .a_we(a_we),
        .a_addr(a_addr), .a_din(a_din), .a_pin(a_pin),
        .a_dout(a_dout), .a_pout(a_pout),
        .b_clk(b_clk), .b_en(b_en), .b_srst(b_srst), .b_we(b_we),
        .b_addr(b_addr), .b_din(b_din), .b_pin(b_pin),
        .b_dout(b_dout), .b_pout(b_pout));

    tdp_ram_wm #(.DW(DW), .PW(PW), .DEPTH(DEPTH), .SEED(SEED),
        .MODE_A(WM_KEEP), .MODE_B(WM_WRITE_FIRST), .SRVAL_A(SRN),
        .SRVAL_B('0), .INIT_A(INN), .INIT_B('0)) i_tdp_ram_wm_keep (
        .glob_rst(glob_rst),
        .a_clk(a_clk), .a_en(n_en), .a_srst(n_srst), .a_we(n_we),
        .a_addr(n_addr), .a_din(n_din), .a_pin(n_pin),
        .a_dout(n_dout), .a_pout(n_pout),
        .b_clk(b_clk), .b_en(1'b0), .b_srst(1'b0), .b_we(1'b0),
        .b_addr('0), .b_din('0), .b_pin('0),
        .b_dout(nb_dout), .b_pout(nb_pout));

    int n_cmp = 0, n_bad = 0;
    logic [W-1:0] mem [DEPTH];
    logic [W-1:0] exp_a, exp_b;

    function automatic logic [W-1:0] boot_word(input int i);
        return W'(i * 37 + SEED);
    endfunction

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One operation on port pt (0=A, 1=B) of the main instance.
    task automatic do_op(input int pt, input bit en, input bit sr, input bit we,
                         input int addr, input logic [W-1:0] w, input string req);
        logic [W-1:0] cur, exp;
        wr_mode_e md;
        md  = (pt == 0) ? MA : MB;
        cur = (pt == 0) ? exp_a : exp_b;
        if (!en)      exp = cur;
        else if (sr)  exp = (pt == 0) ? SRA : SRB;
        else if (we)  exp = (md == WM_WRITE_FIRST) ? w :
                            (md == WM_READ_FIRST) ? mem[addr] : cur;
        else          exp = mem[addr];
        if (en && we) mem[addr] = w;
        if (pt == 0) begin
            @(negedge a_clk);
            a_en = en; a_srst = sr; a_we = we; a_addr = AW'(addr);
            {a_pin, a_din} = w;
            @(negedge a_clk);
            a_en = 0; a_srst = 0; a_we = 0;
            chk(req, {a_pout, a_dout}, exp);
            exp_a = exp;
            chk("R1 other port", {b_pout, b_dout}, exp_b);
        end else begin
            @(negedge b_clk);
            b_en = en; b_srst = sr; b_we = we; b_addr = AW'(addr);
            {b_pin, b_din} = w;
            @(negedge b_clk);
            b_en = 0; b_srst = 0; b_we = 0;
            chk(req, {b_pout, b_dout}, exp);
            exp_b = exp;
            chk("R1 other port", {a_pout, a_dout}, exp_a);
        end
    endtask

    task automatic n_op(input bit en, input bit sr, input bit we, input int addr,
                        input logic [W-1:0] w, input logic [W-1:0] exp, input string req);
        @(negedge a_clk);
        n_en = en; n_srst = sr; n_we = we; n_addr = AW'(addr); {n_pin, n_din} = w;
        @(negedge a_clk);
        n_en = 0; n_srst = 0; n_we = 0;
        chk(req, {n_pout, n_dout}, exp);
    endtask

    task automatic t_reset_state();
        #19;
        chk("R9 init A", {a_pout, a_dout}, INA);
        chk("R9 init B", {b_pout, b_dout}, INB);
        chk("R9 init keep", {n_pout, n_dout}, INN);
        #4 glob_rst = 1'b0;
        exp_a = INA; exp_b = INB;
    endtask

    task automatic t_boot_reads();
        do_op(0, 1, 0, 0, 0,    '0, "R10 boot read A0");
        do_op(0, 1, 0, 0, 2047, '0, "R10 boot read A2047");
        do_op(1, 1, 0, 0, 13,   '0, "R5 R10 boot read B13");
        do_op(1, 1, 0, 0, 500,  '0, "R5 R10 boot read B500");
    endtask

    task automatic t_write_modes();
        do_op(0, 1, 0, 1, 40, 9'h155, "R6 write-first A");
        do_op(0, 1, 0, 1, 41, 9'h0AB, "R6 write-first A parity0");
        do_op(1, 1, 0, 1, 40, 9'h1C3, "R7 read-first B");
        do_op(1, 1, 0, 1, 40, 9'h022, "R7 read-first B again");
        do_op(0, 1, 0, 0, 40, '0,     "R11 A reads B write");
        do_op(1, 1, 0, 0, 41, '0,     "R11 B reads A write");
        do_op(0, 1, 0, 1, 40, 9'h1FF, "R6 A rewrites B location");
        do_op(1, 1, 0, 0, 40, '0,     "R11 B reads A rewrite");
    endtask

    task automatic t_set_reset();
        do_op(0, 1, 1, 0, 77, '0,     "R3 srst A");
        do_op(0, 1, 0, 0, 77, '0,     "R3 mem unchanged A");
        do_op(1, 1, 1, 1, 78, 9'h133, "R4 srst+write B");
        do_op(1, 1, 0, 0, 78, '0,     "R4 write landed B");
        do_op(0, 1, 1, 1, 79, 9'h0C4, "R4 srst+write A");
        do_op(1, 1, 0, 0, 79, '0,     "R4 R11 B sees A srst-write");
    endtask

    task automatic t_disabled();
        do_op(0, 1, 0, 0, 300, '0,     "R5 read A300");
        do_op(0, 0, 1, 1, 300, 9'h0EE, "R2 disabled A holds");
        do_op(0, 0, 0, 0, 301, '0,     "R2 disabled A idle");
        do_op(1, 0, 0, 1, 300, 9'h111, "R2 disabled B holds");
        do_op(1, 1, 0, 0, 300, '0,     "R2 memory kept after disabled writes");
    endtask

    task automatic t_global_reset();
        @(negedge a_clk); #1;
        glob_rst = 1'b1;
        #1;
        chk("R9 async A", {a_pout, a_dout}, INA);
        chk("R9 async B", {b_pout, b_dout}, INB);
        #30;
        chk("R9 held A", {a_pout, a_dout}, INA);
        glob_rst = 1'b0;
        exp_a = INA; exp_b = INB;
        do_op(0, 1, 0, 0, 40, '0, "R9 memory survives global reset");
    endtask

    task automatic t_keep_mode();
        n_op(1, 0, 0, 100, '0,     boot_word(100), "R5 keep-inst read");
        n_op(1, 0, 1, 100, 9'h1E1, boot_word(100), "R8 keep write holds");
        n_op(1, 0, 0, 100, '0,     9'h1E1,         "R8 keep write stored");
        n_op(1, 1, 0, 100, '0,     SRN,            "R3 keep srst");
        n_op(1, 0, 1, 101, 9'h00F, SRN,            "R8 keep holds srst value");
        n_op(1, 0, 0, 101, '0,     9'h00F,         "R8 second write stored");
    endtask

    initial begin
        for (int i = 0; i < DEPTH; i++) mem[i] = boot_word(i);
        exp_a = INA; exp_b = INB;
        t_reset_state();
        t_boot_reads();
        t_write_modes();
        t_set_reset();
        t_disabled();
        t_global_reset();
        t_keep_mode();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #100000;
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule